// File: doc/BRIEF.md
# DMA Interrupt Cause Register Block

This block collects interrupt causes from a multi-channel DMA engine and presents them to software as a small set of 32-bit registers. It keeps one transfer-done flag per channel and a single error flag, plus one interrupt enable per channel. It drives a single interrupt request towards the processor's interrupt controller. The number of implemented channels is a parameter of up to 32. Register bits above that count are inert.

Flags are set by single-cycle pulses from the DMA engine and are cleared only by writing 1 to them. Enables are turned on and off through separate set and clear registers, so software never needs a read-modify-write sequence. The register bus is full-word only and has no wait states: a write takes effect at the clock edge, and read data follows the word address combinationally.

Top module: `dma_irq_regs`

## Requirements
- R1: Synchronous active-high reset clears every done flag, the error flag, every enable and the interrupt output.
- R2: An error pulse sets the error flag, which reads as bit 0 at word address 0; bits 31..1 of that word always read as zero.
- R3: Writing word address 0 with bit 0 = 1 clears the error flag; writing it with bit 0 = 0 leaves the flag unchanged.
- R4: A done pulse on channel n sets bit n of word address 1, whether or not channel n is enabled.
- R5: Writing word address 1 clears each done flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R6: When a set pulse and a write-1 clear reach the same flag (done or error) in one cycle, the flag ends up set.
- R7: Writing 1 to bit n of word address 2 enables channel n, and writing 0 changes nothing; reading word address 2 returns the enable vector.
- R8: Writing 1 to bit n of word address 3 disables channel n, and writing 0 changes nothing; reading word address 3 also returns the enable vector.
- R9: Bits at positions NUM_CH and above read as zero in words 1 to 3, and writes to those bits have no effect.
- R10: The interrupt output is registered. It is 1 in the cycle after a state in which the error flag is set, or some done flag is set together with its enable, and 0 otherwise.
- R11: Word addresses 4 and above read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_addr_i | input | ADDR_W | Register word index (0 error, 1 done flags, 2 enable set, 3 enable clear) |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the addressed word, combinational |
| done_pulse_i | input | NUM_CH | Per-channel transfer-done pulses from the DMA engine |
| err_pulse_i | input | 1 | Error pulse from the DMA engine |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A pulse or write presented before a rising edge changes a flag or enable at that edge. Because reads are combinational, its effect shows on rd_data_o as soon as the address selects the word, and the bench samples read data just after the following falling edge. The interrupt output needs one more register stage, so it is due one full cycle after the state change, and the bench checks it at the falling edge after that. A dedicated sequence shows that the interrupt stays low for that first cycle and stays high for one cycle after the pending flag is cleared.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int REG_W  = 32;
    localparam int MAX_CH = 32;

    // Register words by index on the bus
    typedef enum logic [1:0] {
        SEL_ERR   = 2'd0,
        SEL_DONE  = 2'd1,
        SEL_ENSET = 2'd2,
        SEL_ENCLR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic err_clr;
        logic done_clr;
        logic en_set;
        logic en_clr;
    } wr_strobe_t;

    // Mask of implemented channel bits
    function automatic logic [REG_W-1:0] ch_mask(input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] word_addr_i,
    input  logic              wr_en_i,
    output reg_sel_e          sel_o,
    output logic              hit_o,
    output wr_strobe_t        stb_o
);

    always_comb begin
        sel_o = reg_sel_e'(word_addr_i[1:0]);
        hit_o = (word_addr_i[ADDR_W-1:2] == '0);
        stb_o = '0;
        if (wr_en_i && hit_o) begin
            unique case (sel_o)
                SEL_ERR:   stb_o.err_clr  = 1'b1;
                SEL_DONE:  stb_o.done_clr = 1'b1;
                SEL_ENSET: stb_o.en_set   = 1'b1;
                SEL_ENCLR: stb_o.en_clr   = 1'b1;
                default:   stb_o          = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_irq_cause_bank.sv
module dma_irq_cause_bank #(
    parameter int              WIDTH = 32,
    parameter logic [WIDTH-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_en_i,
    input  logic [WIDTH-1:0] clr_data_i,
    output logic [WIDTH-1:0] flag_o
);

    logic [WIDTH-1:0] flag_q;
    logic [WIDTH-1:0] clr_vec;

    assign clr_vec = clr_en_i ? clr_data_i : '0;

    // A set pulse outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (set_i | (flag_q & ~clr_vec)) & MASK;
    end

    assign flag_o = flag_q;

    // R4 / R2 / R6: a pulse always leaves its flag set
    p_event_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (|(set_i & MASK)) |=> ((flag_o & $past(set_i & MASK)) == $past(set_i & MASK)));

    // R5 / R3: a write-1 without a pulse clears
    p_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_en_i && !(|set_i)) |=> ((flag_o & $past(clr_data_i)) == '0));

    // R9: bits outside the mask never hold
    p_masked_zero_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_o & ~MASK) == '0));

endmodule

// File: rtl/dma_irq_enable_bank.sv
module dma_irq_enable_bank #(
    parameter int              WIDTH = 32,
    parameter logic [WIDTH-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en_i,
    input  logic             clr_en_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] en_o
);

    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] set_vec;
    logic [WIDTH-1:0] clr_vec;

    assign set_vec = set_en_i ? data_i : '0;
    assign clr_vec = clr_en_i ? data_i : '0;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= ((en_q | set_vec) & ~clr_vec) & MASK;
    end

    assign en_o = en_q;

    // R7: set register turns bits on
    p_enable_set_r7: assert property (@(posedge clk) disable iff (rst)
        set_en_i |=> ((en_o & $past(data_i & MASK)) == $past(data_i & MASK)));

    // R8: clear register turns bits off
    p_enable_clr_r8: assert property (@(posedge clk) disable iff (rst)
        clr_en_i |=> ((en_o & $past(data_i)) == '0));

    // R7 / R8: without a write the enables hold
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!set_en_i && !clr_en_i) |=> $stable(en_o));

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] word_addr_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic [NUM_CH-1:0] done_pulse_i,
    input  logic              err_pulse_i,
    output logic              irq_o
);

    localparam logic [REG_W-1:0] CH_MASK = ch_mask(NUM_CH);

    reg_sel_e         sel;
    logic             hit;
    wr_strobe_t       stb;
    logic [REG_W-1:0] done_w;
    logic [REG_W-1:0] done_flags;
    logic [REG_W-1:0] enables;
    logic [0:0]       err_flag;
    logic             pend;
    logic             irq_q;

    always_comb begin
        done_w = '0;
        done_w[NUM_CH-1:0] = done_pulse_i;
    end

    dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .word_addr_i (word_addr_i),
        .wr_en_i     (wr_en_i),
        .sel_o       (sel),
        .hit_o       (hit),
        .stb_o       (stb)
    );

    dma_irq_cause_bank #(.WIDTH(REG_W), .MASK(CH_MASK)) u_done (
        .clk        (clk),
        .rst        (rst),
        .set_i      (done_w),
        .clr_en_i   (stb.done_clr),
        .clr_data_i (wr_data_i),
        .flag_o     (done_flags)
    );

    dma_irq_cause_bank #(.WIDTH(1), .MASK(1'b1)) u_err (
        .clk        (clk),
        .rst        (rst),
        .set_i      (err_pulse_i),
        .clr_en_i   (stb.err_clr),
        .clr_data_i (wr_data_i[0:0]),
        .flag_o     (err_flag)
    );

    dma_irq_enable_bank #(.WIDTH(REG_W), .MASK(CH_MASK)) u_en (
        .clk      (clk),
        .rst      (rst),
        .set_en_i (stb.en_set),
        .clr_en_i (stb.en_clr),
        .data_i   (wr_data_i),
        .en_o     (enables)
    );

    always_comb begin
        rd_data_o = '0;
        if (hit) begin
            unique case (sel)
                SEL_ERR:   rd_data_o[0] = err_flag[0];
                SEL_DONE:  rd_data_o    = done_flags;
                SEL_ENSET: rd_data_o    = enables;
                SEL_ENCLR: rd_data_o    = enables;
                default:   rd_data_o    = '0;
            endcase
        end
    end

    assign pend = err_flag[0] | (|(done_flags & enables));

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pend;
    end

    assign irq_o = irq_q;

    // R10: interrupt follows pending state one cycle later
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
        (err_flag[0] || (|(done_flags & enables))) |=> irq_o);
    p_irq_fall_r10: assert property (@(posedge clk) disable iff (rst)
        (!err_flag[0] && !(|(done_flags & enables))) |=> !irq_o);

    // R2: reserved bits of the error word
    p_err_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
        (word_addr_i == ADDR_W'(0)) |-> (rd_data_o[REG_W-1:1] == '0));

    // R9: unimplemented channel bits read zero
    p_hi_bits_r9: assert property (@(posedge clk) disable iff (rst)
        ((rd_data_o & ~CH_MASK) == '0));

    // R11: unmapped words read zero
    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (rd_data_o == '0));

    // R1: nothing pending right after reset
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!irq_o && done_flags == '0 && enables == '0 && !err_flag[0]));

endmodule

// File: tb/tb_dma_irq_regs.sv
module tb_dma_irq_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int AW         = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  word_addr = '0;
    logic           wr_en = 1'b0;
    logic [31:0]    wr_data = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] done = '0;
    logic           err = 1'b0;
    logic           irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_regs #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
        .clk          (clk),
        .rst          (rst),
        .word_addr_i  (word_addr),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .rd_data_o    (rd_data),
        .done_pulse_i (done),
        .err_pulse_i  (err),
        .irq_o        (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  dn;
        logic        er;
        logic [2:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 32'h0,          8'h05, 1'b0, 3'd1, 32'h05, 1'b0, 4'd4},  // R4 flags without enable
        '{1'b1, 3'd2, 32'hFFFF_FF01,  8'h00, 1'b0, 3'd2, 32'h01, 1'b1, 4'd9},  // R9 / R7 high bits dropped
        '{1'b1, 3'd2, 32'h0,          8'h00, 1'b0, 3'd3, 32'h01, 1'b1, 4'd8},  // R7 zero write, R8 readback
        '{1'b1, 3'd1, 32'h04,         8'h00, 1'b0, 3'd1, 32'h01, 1'b1, 4'd5},  // R5 clear one flag
        '{1'b1, 3'd1, 32'h0,          8'h00, 1'b0, 3'd1, 32'h01, 1'b1, 4'd5},  // R5 zero write
        '{1'b1, 3'd3, 32'h01,         8'h00, 1'b0, 3'd2, 32'h00, 1'b0, 4'd8},  // R8 disable
        '{1'b1, 3'd1, 32'h01,         8'h01, 1'b0, 3'd1, 32'h01, 1'b0, 4'd6},  // R6 pulse beats clear
        '{1'b1, 3'd1, 32'hFFFF_FFFF,  8'h00, 1'b0, 3'd1, 32'h00, 1'b0, 4'd5},  // R5 clear all
        '{1'b0, 3'd0, 32'h0,          8'h00, 1'b1, 3'd0, 32'h01, 1'b1, 4'd2},  // R2 error set
        '{1'b1, 3'd0, 32'hFFFF_FFFE,  8'h00, 1'b0, 3'd0, 32'h01, 1'b1, 4'd3},  // R3 bit0 zero
        '{1'b1, 3'd0, 32'h01,         8'h00, 1'b0, 3'd0, 32'h00, 1'b0, 4'd3},  // R3 clear
        '{1'b1, 3'd2, 32'h80,         8'h80, 1'b0, 3'd1, 32'h80, 1'b1, 4'd10}, // R10 top channel
        '{1'b1, 3'd4, 32'hFFFF_FFFF,  8'h00, 1'b0, 3'd2, 32'h80, 1'b1, 4'd11}, // R11 write ignored
        '{1'b1, 3'd5, 32'hFFFF_FFFF,  8'h00, 1'b0, 3'd5, 32'h00, 1'b1, 4'd11}, // R11 reads zero
        '{1'b1, 3'd0, 32'h01,         8'h00, 1'b1, 3'd0, 32'h01, 1'b1, 4'd6}   // R6 on error flag
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic read_word(input int req, input logic [2:0] a, input logic [31:0] exp);
        word_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        wr_en = v.wr; word_addr = v.waddr; wr_data = v.wdata; done = v.dn; err = v.er;
        @(negedge clk);
        wr_en = 1'b0; done = '0; err = 1'b0;
        read_word(int'(v.req), v.raddr, v.exp_rd);
        @(negedge clk);
        check(10, {31'b0, irq}, {31'b0, v.exp_irq});
    endtask

    task automatic check_cleared();
        // R1: every word and the interrupt are zero
        for (int a = 0; a < 4; a++) read_word(1, 3'(a), 32'h0);
        check(1, {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_cleared();

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset in the middle of activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_cleared();

        // R10: latency of the interrupt, rise and fall
        @(negedge clk);
        wr_en = 1'b1; word_addr = 3'd2; wr_data = 32'h02;
        @(negedge clk);
        wr_en = 1'b0; done = 8'h02;
        @(negedge clk);
        done = '0;
        check(10, {31'b0, irq}, 32'h0);
        @(negedge clk);
        check(10, {31'b0, irq}, 32'h1);
        wr_en = 1'b1; word_addr = 3'd1; wr_data = 32'h02;
        @(negedge clk);
        wr_en = 1'b0;
        check(10, {31'b0, irq}, 32'h1);
        @(negedge clk);
        check(10, {31'b0, irq}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule